// File: doc/BRIEF.md
# Selectable Line Anti-Flicker Filter

This block smooths a progressive pixel stream vertically before it is interlaced for a television display. Thin horizontal detail that is one line tall would otherwise show on only one field and flicker at the field rate. Each sample carries one luma value and one chroma value in 4:2:2 order. The block blends every sample with the samples at the same column on neighbouring lines, which it holds in internal line stores. Luma and chroma are filtered separately.

Software picks one of three kernels through a small write-only register port. The first is a two-tap average of the current line and the line above, with its luma then passed through a programmable gamma table; it suits text. The second is a three-tap weighted average centred on the previous line; it suits desktop graphics. The third is a full bypass for large areas of moving video. A new kernel choice waits for the next start-of-frame, so no frame mixes kernels.

Top module: `afl_filter`

## Requirements
- R1: In bypass every accepted sample, including samples past the line length, appears on the output one clock later with luma, chroma, start-of-line and start-of-frame unchanged.
- R2: In two-line mode each output component is (current + above + 1) >> 1, where "above" is the same column of the previous line; on the first line of a frame "above" is the current sample itself.
- R3: In two-line mode the blended luma is replaced by gamma table entry [luma]; chroma never goes through the table, and three-line mode and bypass do not use it. After reset the table is the identity. A write to address 2 stores cfg_wdata[7:0] at entry cfg_wdata[15:8].
- R4: In three-line mode the output is one line behind the input: while line n arrives, line n-1 is emitted as (above + 2*centre + below + 2) >> 2 with centre = line n-1, below = line n, above = line n-2, or the centre itself when the centre is the frame's first line. The first line of a frame gives no output unless R5 applies.
- R5: When a three-line frame follows a three-line frame, the last line of the earlier frame is emitted during the first line of the new one, with "below" equal to the centre. When either frame uses another mode, that line is never emitted.
- R6: A write to address 0 sets the mode from cfg_wdata[1:0]: 0 bypass, 1 two-line, 2 three-line, 3 bypass. The new mode takes effect only at the next sample flagged start-of-frame.
- R7: A write to address 1 sets the active line length from cfg_wdata[10:0], with values above 1024 treated as 1024. In the two filtering modes, samples at a column index equal to or beyond that length give no output.
- R8: out_sol marks the first sample of each emitted line. out_sof marks only the first sample of the first emitted line of a frame, and never a line emitted under R5.
- R9: After reset the output is idle, the mode is bypass and the line length is 1024.
- R10: The output is valid only in the clock that follows an accepted input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 line length, 2 gamma entry |
| cfg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Input sample is present |
| in_sol | input | 1 | Input sample is the first of its line |
| in_sof | input | 1 | Input sample is the first of its frame |
| in_luma | input | 8 | Input luma |
| in_chroma | input | 8 | Input chroma (Cb or Cr, alternating) |
| out_valid | output | 1 | Output sample is present |
| out_sol | output | 1 | Output sample is the first of its line |
| out_sof | output | 1 | Output sample is the first of its frame |
| out_luma | output | 8 | Filtered luma |
| out_chroma | output | 8 | Filtered chroma |

## Verification
The kernels are driven with alternating dark and bright rows, which is the case flicker comes from. This pattern shows whether the right neighbour line is blended with the right weight. Linear ramps and a quadratic pattern follow; with these, a swapped above/below operand, a wrong edge replication or a rounding slip gives a different value. One-line frames and chains of three-line frames check the one-line lag and the last-line hand-over between frames. Lines longer than the active length, an inverting gamma table, a mode write in the middle of a frame and mode code 3 separate the range check, the luma-only gamma path and the start-of-frame mode switch.

// File: rtl/afl_pkg.sv
package afl_pkg;

   typedef enum logic [1:0] {
      MODE_BYPASS = 2'd0,
      MODE_TWO    = 2'd1,
      MODE_THREE  = 2'd2
   } afl_mode_e;

   localparam logic [1:0] ADDR_MODE  = 2'd0;
   localparam logic [1:0] ADDR_LEN   = 2'd1;
   localparam logic [1:0] ADDR_GAMMA = 2'd2;

   // code 3 is an alias of bypass
   function automatic afl_mode_e decode_mode(input logic [1:0] code);
      case (code)
         2'd1:    return MODE_TWO;
         2'd2:    return MODE_THREE;
         default: return MODE_BYPASS;
      endcase
   endfunction

endpackage

// File: rtl/afl_line_store.sv
// Two cascaded line memories: up1 is the previous line, up2 the one before.
module afl_line_store #(
   parameter int W     = 16,
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  up1,
   output logic [W-1:0]  up2
);
   logic [W-1:0] mem_near [DEPTH];
   logic [W-1:0] mem_far  [DEPTH];

   assign up1 = mem_near[addr];
   assign up2 = mem_far[addr];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_near[addr] <= din;
         mem_far[addr]  <= mem_near[addr];
      end
   end
endmodule

// File: rtl/afl_blend.sv
// Binomial vertical blend, round to nearest: (1,1)/2 or (1,2,1)/4.
module afl_blend #(
   parameter int W = 8
) (
   input  logic         three,
   input  logic [W-1:0] up,
   input  logic [W-1:0] mid,
   input  logic [W-1:0] dn,
   output logic [W-1:0] y
);
   logic [W+1:0] sum2, sum3;

   always_comb begin
      sum2 = (W+2)'(up) + (W+2)'(mid) + (W+2)'(1);
      sum3 = (W+2)'(up) + ((W+2)'(mid) << 1) + (W+2)'(dn) + (W+2)'(2);
      y    = three ? sum3[W+1:2] : sum2[W:1];
   end
endmodule

// File: rtl/afl_gamma.sv
// Programmable lookup table, identity after reset.
module afl_gamma #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_idx,
   input  logic [W-1:0] wr_val,
   input  logic [W-1:0] rd_idx,
   output logic [W-1:0] rd_val
);
   localparam int ENTRIES = 1 << W;

   logic [W-1:0] lut [ENTRIES];

   assign rd_val = lut[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) lut[i] <= W'(i);
      end else if (wr_en) begin
         lut[wr_idx] <= wr_val;
      end
   end
endmodule

// File: rtl/afl_filter.sv
module afl_filter
   import afl_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MAX_LEN = 1024,
   parameter int REG_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              in_valid,
   input  logic              in_sol,
   input  logic              in_sof,
   input  logic [DATA_W-1:0] in_luma,
   input  logic [DATA_W-1:0] in_chroma,
   output logic              out_valid,
   output logic              out_sol,
   output logic              out_sof,
   output logic [DATA_W-1:0] out_luma,
   output logic [DATA_W-1:0] out_chroma
);
   localparam int AW    = $clog2(MAX_LEN);
   localparam int LEN_W = $clog2(MAX_LEN + 1);
   localparam int NCOMP = 2;
   localparam int PIX_W = NCOMP * DATA_W;
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

   if (DATA_W < 2 || DATA_W > 10) begin : g_bad_width
      $error("afl_filter: DATA_W must lie in 2..10");
   end
   if (MAX_LEN < 2) begin : g_bad_len
      $error("afl_filter: MAX_LEN must be at least 2");
   end
   if (REG_W < 2 * DATA_W || REG_W < LEN_W) begin : g_bad_reg
      $error("afl_filter: REG_W too narrow for gamma or length writes");
   end

   // ---------------- configuration ----------------
   afl_mode_e        pend_mode, act_mode;
   logic [LEN_W-1:0] len_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_mode <= MODE_BYPASS;
         len_r     <= LEN_MAX;
      end else if (cfg_we) begin
         if (cfg_addr == ADDR_MODE)
            pend_mode <= decode_mode(cfg_wdata[1:0]);
         if (cfg_addr == ADDR_LEN)
            len_r <= (cfg_wdata[LEN_W-1:0] > LEN_MAX) ? LEN_MAX : cfg_wdata[LEN_W-1:0];
      end
   end

   // ---------------- position tracking ----------------
   logic [LEN_W-1:0] col_cnt, col;
   logic [1:0]       line_cnt, line_idx;
   logic             tail_r, ge2_r, tail_now, ge2_now, in_range;
   afl_mode_e        eff_mode;

   always_comb begin
      col      = in_sol ? '0 : col_cnt;
      line_idx = in_sof ? 2'd0 : (in_sol ? ((line_cnt == 2'd2) ? 2'd2 : line_cnt + 2'd1) : line_cnt);
      eff_mode = in_sof ? pend_mode : act_mode;
      tail_now = in_sof ? (act_mode == MODE_THREE && pend_mode == MODE_THREE) : tail_r;
      ge2_now  = in_sof ? (line_cnt != 2'd0) : ge2_r;
      in_range = col < len_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_cnt  <= '0;
         line_cnt <= '0;
         act_mode <= MODE_BYPASS;
         tail_r   <= 1'b0;
         ge2_r    <= 1'b0;
      end else if (in_valid) begin
         col_cnt  <= (&col) ? col : col + LEN_W'(1);
         line_cnt <= line_idx;
         act_mode <= eff_mode;
         tail_r   <= tail_now;
         ge2_r    <= ge2_now;
      end
   end

   // ---------------- line stores ----------------
   logic [NCOMP-1:0][DATA_W-1:0] pix_in, near_pix, far_pix, blended;
   logic [PIX_W-1:0]             near_flat, far_flat;

   assign pix_in   = {in_chroma, in_luma};
   assign near_pix = near_flat;
   assign far_pix  = far_flat;

   afl_line_store #(.W(PIX_W), .DEPTH(MAX_LEN), .AW(AW)) u_store (
      .clk   (clk),
      .wr_en (in_valid && in_range),
      .addr  (col[AW-1:0]),
      .din   (pix_in),
      .up1   (near_flat),
      .up2   (far_flat)
   );

   // ---------------- per-component kernels ----------------
   logic three_sel;
   assign three_sel = (eff_mode == MODE_THREE);

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      logic [DATA_W-1:0] op_up, op_mid, op_dn;

      always_comb begin
         if (!three_sel) begin
            op_mid = pix_in[k];
            op_up  = (line_idx == 2'd0) ? pix_in[k] : near_pix[k];
            op_dn  = '0;
         end else if (line_idx == 2'd0) begin
            op_mid = near_pix[k];
            op_up  = ge2_now ? far_pix[k] : near_pix[k];
            op_dn  = near_pix[k];
         end else begin
            op_mid = near_pix[k];
            op_up  = (line_idx == 2'd1) ? near_pix[k] : far_pix[k];
            op_dn  = pix_in[k];
         end
      end

      afl_blend #(.W(DATA_W)) u_blend (
         .three (three_sel),
         .up    (op_up),
         .mid   (op_mid),
         .dn    (op_dn),
         .y     (blended[k])
      );
   end

   // ---------------- gamma on luma ----------------
   logic [DATA_W-1:0] gamma_luma;

   afl_gamma #(.W(DATA_W)) u_gamma (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && cfg_addr == ADDR_GAMMA),
      .wr_idx (cfg_wdata[2*DATA_W-1:DATA_W]),
      .wr_val (cfg_wdata[DATA_W-1:0]),
      .rd_idx (blended[0]),
      .rd_val (gamma_luma)
   );

   // ---------------- output stage ----------------
   logic              v_d, sol_d, sof_d;
   logic [DATA_W-1:0] luma_d, chroma_d;

   always_comb begin
      case (eff_mode)
         MODE_TWO: begin
            v_d      = in_range;
            sol_d    = (col == '0);
            sof_d    = (col == '0) && (line_idx == 2'd0);
            luma_d   = gamma_luma;
            chroma_d = blended[1];
         end
         MODE_THREE: begin
            v_d      = in_range && (line_idx != 2'd0 || tail_now);
            sol_d    = (col == '0);
            sof_d    = (col == '0) && (line_idx == 2'd1);
            luma_d   = blended[0];
            chroma_d = blended[1];
         end
         default: begin
            v_d      = 1'b1;
            sol_d    = in_sol;
            sof_d    = in_sof;
            luma_d   = in_luma;
            chroma_d = in_chroma;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sol    <= 1'b0;
         out_sof    <= 1'b0;
         out_luma   <= '0;
         out_chroma <= '0;
      end else begin
         out_valid <= in_valid && v_d;
         out_sol   <= in_valid && v_d && sol_d;
         out_sof   <= in_valid && v_d && sof_d;
         if (in_valid) begin
            out_luma   <= luma_d;
            out_chroma <= chroma_d;
         end
      end
   end
endmodule

// File: rtl/afl_checker.sv
module afl_checker
   import afl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sof,
   input logic [DATA_W-1:0] in_luma,
   input logic [DATA_W-1:0] in_chroma,
   input logic              out_valid,
   input logic              out_sol,
   input logic              out_sof,
   input logic [DATA_W-1:0] out_luma,
   input logic [DATA_W-1:0] out_chroma,
   input logic [1:0]        act_mode,
   input logic [1:0]        pend_mode
);
   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_bypass_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !in_sof && act_mode == MODE_BYPASS) |->
         (out_valid && out_luma == $past(in_luma) && out_chroma == $past(in_chroma)));

   assert_sof_in_sol_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> (out_sol && out_valid));

   assert_mode_at_sof_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_mode) |-> $past(in_valid && in_sof));

   assert_three_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_sof && pend_mode == MODE_THREE && act_mode != MODE_THREE) |-> !out_valid);
endmodule

bind afl_filter afl_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sof     (in_sof),
   .in_luma    (in_luma),
   .in_chroma  (in_chroma),
   .out_valid  (out_valid),
   .out_sol    (out_sol),
   .out_sof    (out_sof),
   .out_luma   (out_luma),
   .out_chroma (out_chroma),
   .act_mode   (act_mode),
   .pend_mode  (pend_mode)
);

// File: tb/afl_filter_bench.sv
module afl_filter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NTAB = 8;
   // {mode code, pattern kind, lines, length}
   localparam logic [31:0] TABLE [NTAB] = '{
      {8'd1, 8'd0, 8'd4, 8'd4},   // two-line, stripes (R2)
      {8'd2, 8'd0, 8'd4, 8'd4},   // three-line, no tail (R4)
      {8'd2, 8'd1, 8'd3, 8'd4},   // three after three: tail (R5)
      {8'd0, 8'd2, 8'd3, 8'd5},   // bypass, tail dropped (R1, R5)
      {8'd2, 8'd2, 8'd1, 8'd4},   // one-line three frame: no output (R4)
      {8'd2, 8'd1, 8'd3, 8'd4},   // tail from one-line frame (R5)
      {8'd3, 8'd1, 8'd2, 8'd4},   // code 3 is bypass (R6)
      {8'd1, 8'd2, 8'd1, 8'd6}    // two-line single line (R2)
   };

   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_addr = 0;
   logic [15:0] cfg_wdata = 0;
   logic        in_valid = 0, in_sol = 0, in_sof = 0;
   logic [7:0]  in_luma = 0, in_chroma = 0;
   logic        out_valid, out_sol, out_sof;
   logic [7:0]  out_luma, out_chroma;

   always #(CLK_PERIOD/2) clk = ~clk;

   afl_filter u_afl_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_luma(in_luma), .in_chroma(in_chroma),
      .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_luma(out_luma), .out_chroma(out_chroma)
   );

   int checks = 0, fails = 0;
   int exp_l [4096], exp_c [4096], exp_sol [4096], exp_sof [4096], exp_req [4096];
   int wr_ptr = 0, rd_ptr = 0;
   int gam [256];
   int pend = 0, prev_mode = 0, prev_kind = 0, prev_nl = 0;

   function automatic int pat(int kind, int r, int c, int ch);
      case (kind)
         0:       return (ch == 0) ? ((r % 2) ? 235 : 16) : ((((r % 2) ? 90 : 170) + c * 3) & 255);
         1:       return (r * 40 + c * 9 + ch * 77) & 255;
         default: return (r * r * 53 + c * 29 + ch * 101 + 7) & 255;
      endcase
   endfunction

   function automatic int dec(int code);
      return (code == 1) ? 1 : (code == 2) ? 2 : 0;
   endfunction

   function automatic int avg2(int u, int m);
      return (u + m + 1) / 2;
   endfunction

   function automatic int avg3(int u, int m, int d);
      return (u + 2 * m + d + 2) / 4;
   endfunction

   task automatic push(int l, int c, int sol, int sof, int req);
      exp_l[wr_ptr] = l; exp_c[wr_ptr] = c; exp_sol[wr_ptr] = sol;
      exp_sof[wr_ptr] = sof; exp_req[wr_ptr] = req;
      wr_ptr++;
   endtask

   task automatic fail_line(string req, string what, int act, int exp);
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
   endtask

   // monitor: compare every output sample with the expectation list
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (rd_ptr >= wr_ptr) begin
            fail_line("R7", "unexpected output sample", 1, 0);
         end else begin
            if (out_luma != exp_l[rd_ptr] || out_chroma != exp_c[rd_ptr]) begin
               fails++;
               $display("FAIL R%0d sample %0d: actual luma %0d chroma %0d expected luma %0d chroma %0d",
                        exp_req[rd_ptr], rd_ptr, out_luma, out_chroma, exp_l[rd_ptr], exp_c[rd_ptr]);
            end
            if (out_sol != exp_sol[rd_ptr][0] || out_sof != exp_sof[rd_ptr][0]) begin
               fails++;
               $display("FAIL R8 markers at sample %0d: actual sol %0d sof %0d expected sol %0d sof %0d",
                        rd_ptr, out_sol, out_sof, exp_sol[rd_ptr], exp_sof[rd_ptr]);
            end
            rd_ptr++;
         end
      end
   end

   task automatic cfg_write(int addr, int data);
      @(negedge clk);
      cfg_we = 1; cfg_addr = 2'(addr); cfg_wdata = 16'(data);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic set_mode(int code);
      cfg_write(0, code);
      pend = dec(code);
   endtask

   // expected output of one frame, computed from the requirement formulas
   task automatic model_frame(int fm, int kind, int nl, int npix, int len);
      int lim = (npix < len) ? npix : len;
      if (fm == 2 && prev_mode == 2) begin   // R5 tail of previous frame
         for (int c = 0; c < lim; c++) begin
            int v[2];
            for (int ch = 0; ch < 2; ch++) begin
               int m = pat(prev_kind, prev_nl - 1, c, ch);
               int u = (prev_nl >= 2) ? pat(prev_kind, prev_nl - 2, c, ch) : m;
               v[ch] = avg3(u, m, m);
            end
            push(v[0], v[1], c == 0, 0, 5);
         end
      end
      if (fm == 0) begin                      // R1
         for (int r = 0; r < nl; r++)
            for (int c = 0; c < npix; c++)
               push(pat(kind, r, c, 0), pat(kind, r, c, 1), c == 0, r == 0 && c == 0, 1);
      end else if (fm == 1) begin             // R2, R3
         for (int r = 0; r < nl; r++)
            for (int c = 0; c < lim; c++) begin
               int v[2];
               for (int ch = 0; ch < 2; ch++) begin
                  int cur = pat(kind, r, c, ch);
                  int u = (r == 0) ? cur : pat(kind, r - 1, c, ch);
                  v[ch] = avg2(u, cur);
               end
               push(gam[v[0]], v[1], c == 0, r == 0 && c == 0, 2);
            end
      end else begin                          // R4
         for (int r = 1; r < nl; r++)
            for (int c = 0; c < lim; c++) begin
               int v[2];
               for (int ch = 0; ch < 2; ch++) begin
                  int m = pat(kind, r - 1, c, ch);
                  int u = (r == 1) ? m : pat(kind, r - 2, c, ch);
                  v[ch] = avg3(u, m, pat(kind, r, c, ch));
               end
               push(v[0], v[1], c == 0, r == 1 && c == 0, 4);
            end
      end
      prev_mode = fm; prev_kind = kind; prev_nl = nl;
   endtask

   task automatic run_frame(int kind, int nl, int npix, int len, int midmode, string tag);
      model_frame(pend, kind, nl, npix, len);
      for (int r = 0; r < nl; r++) begin
         for (int c = 0; c < npix; c++) begin
            @(negedge clk);
            in_valid = 1; in_sol = (c == 0); in_sof = (r == 0 && c == 0);
            in_luma = 8'(pat(kind, r, c, 0)); in_chroma = 8'(pat(kind, r, c, 1));
            if (r == 1 && c == 0 && midmode >= 0) begin
               cfg_we = 1; cfg_addr = 2'd0; cfg_wdata = 16'(midmode);
            end else begin
               cfg_we = 0;
            end
         end
         @(negedge clk);
         in_valid = 0; in_sol = 0; in_sof = 0; cfg_we = 0;
      end
      if (midmode >= 0) pend = dec(midmode);
      repeat (3) @(negedge clk);
      checks++;
      if (rd_ptr != wr_ptr) fail_line(tag, "output sample count", rd_ptr, wr_ptr);
      rd_ptr = wr_ptr;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) gam[i] = i;
      repeat (4) @(negedge clk);
      checks++;   // R9 idle output in reset
      if (out_valid !== 1'b0) fail_line("R9", "out_valid during reset", out_valid, 0);
      rst_n = 1;
      @(negedge clk);
      checks++;   // R9 idle after reset
      if (out_valid !== 1'b0) fail_line("R9", "out_valid after reset", out_valid, 0);

      // R9: default bypass mode, then default length 1024 in two-line mode
      run_frame(1, 2, 6, 1024, -1, "R9");
      set_mode(1);
      run_frame(2, 2, 6, 1024, -1, "R9");

      // table of frames
      for (int i = 0; i < NTAB; i++) begin
         set_mode(int'(TABLE[i][31:24]));
         cfg_write(1, int'(TABLE[i][7:0]));
         run_frame(int'(TABLE[i][23:16]), int'(TABLE[i][15:8]),
                   int'(TABLE[i][7:0]), int'(TABLE[i][7:0]), -1, "R4");
      end

      // R7: samples past the active length are dropped in two-line mode
      set_mode(1);
      cfg_write(1, 3);
      run_frame(2, 3, 5, 3, -1, "R7");
      // R7: three-line mode with over-long lines
      set_mode(2);
      run_frame(1, 3, 5, 3, -1, "R7");

      // R3: inverting gamma, luma only, only in two-line mode
      for (int i = 0; i < 256; i++) begin
         cfg_write(2, (i << 8) | (255 - i));
         gam[i] = 255 - i;
      end
      cfg_write(1, 4);
      set_mode(1);
      run_frame(1, 3, 4, 4, -1, "R3");
      set_mode(2);
      run_frame(0, 3, 4, 4, -1, "R3");

      // R6: mode write in mid-frame waits for the next start-of-frame
      set_mode(1);
      run_frame(2, 3, 4, 4, 0, "R6");
      run_frame(1, 2, 4, 4, -1, "R6");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule